// File: doc/BRIEF.md
# Receive Frame Commit Gate

The block stands between an Ethernet receive MAC and the host. The MAC sends a byte stream with start and end markers. With the end marker it also gives the frame's broadcast, multicast, CRC-error and dribble-nibble flags. The gate writes bytes into a circular byte store behind a speculative write pointer. A frame becomes visible to the host only if it ends cleanly. A frame that ends with a CRC error or a dribble nibble (one to seven extra bits after the last whole byte) is thrown away in a single cycle by moving the pointer back to where the frame began. The same happens to a frame that runs out of room.

Each committed frame leaves a record in a small status queue. The record holds the frame's length and its address-class bits. The host reads bytes one per cycle through a valid/ready port. The port marks the last byte of each frame, and the address-class outputs always describe the frame now at the head. Two readiness flags tell the host that a whole good frame is waiting. An errored frame never raises them.

Top module: `rx_frame_gate`

## Requirements
- R1: After reset, outValid, rdyReg, rdyFifo and all five status outputs are 0.
- R2: A clean frame whose end beat is accepted raises outValid, rdyReg and rdyFifo in the next cycle. Its bytes come out in arrival order, and outLast is 1 exactly on its final byte.
- R3: statBcast and statMcast equal the inBcast and inMcast values given on the end beat of the frame now at the head. Both are 0 while no frame is waiting.
- R4: A frame with inCrcErr=1 on its end beat is discarded: no byte of it is ever presented and the ready flags stay low for it. statCrcErr reads 1 from the cycle after that end beat.
- R5: A frame with inDribble=1 on its end beat is discarded the same way, and statDribble reads 1 from the cycle after that end beat.
- R6: Once the final byte of the head frame is taken, the flags and outValid drop if no other frame is committed. Otherwise the next frame's data and status take its place in the following cycle.
- R7: If a byte arrives while the byte store holds DATA_DEPTH bytes, its frame is dropped and later beats are ignored until the next start marker. A clean frame that ends while STAT_DEPTH frames are queued is also dropped. In both cases statOverflow goes to 1 and stays there until reset.
- R8: While outValid=1 and outReady=0, outValid, outData and outLast hold their values.
- R9: A beat without inSof outside a frame is ignored. A start marker inside an unfinished frame discards the partial frame and begins a new one.
- R10: statCrcErr and statDribble are rewritten on every accepted end beat, so a clean end beat clears both. A frame dropped for lack of space leaves them unchanged.
- R11: A frame of exactly DATA_DEPTH bytes fits into an empty store and is delivered whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Receive beat present |
| inData | input | 8 | Receive byte |
| inSof | input | 1 | Beat is the first byte of a frame |
| inEof | input | 1 | Beat is the last byte of a frame |
| inBcast | input | 1 | Frame is broadcast (sampled on end beat) |
| inMcast | input | 1 | Frame is multicast (sampled on end beat) |
| inCrcErr | input | 1 | Frame failed its CRC (sampled on end beat) |
| inDribble | input | 1 | Frame ended with a dribble nibble (sampled on end beat) |
| outReady | input | 1 | Host accepts a byte this cycle |
| outValid | output | 1 | Host byte present |
| outData | output | 8 | Host byte |
| outLast | output | 1 | Host byte is the frame's last |
| statBcast | output | 1 | Head frame is broadcast |
| statMcast | output | 1 | Head frame is multicast |
| statCrcErr | output | 1 | Last ended frame had a CRC error |
| statDribble | output | 1 | Last ended frame had a dribble nibble |
| statOverflow | output | 1 | Sticky: a frame was lost for lack of space |
| rdyReg | output | 1 | A good frame is ready for register reads |
| rdyFifo | output | 1 | Receive FIFO holds a readable frame |

## Verification
The bench builds the gate with DATA_DEPTH=32 and STAT_DEPTH=4. With these values a 33-byte frame runs out of room, and a 32-byte frame fills the store exactly, so both sides of the byte-store limit are tested. A fifth queued frame reaches the status-queue limit after only a few short frames. The random rounds keep at most three short frames in flight, so those rounds never overflow. That leaves the overflow cases to the directed tests, which must still see the bit stay set afterwards.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  typedef struct packed {
    logic wrEn;      // store the current byte
    logic restart;   // start of frame: write from committed pointer
    logic commit;    // clean end: publish frame and push status
    logic rollback;  // discard speculative bytes
    logic rdEn;      // host took a byte
    logic pop;       // host took the last byte of the head frame
  } rxg_strobe_t;
endpackage

// File: rtl/rxg_datapath.sv
module rxg_datapath
  import rxg_pkg::*;
#(
  parameter int DATA_DEPTH = 64,
  parameter int STAT_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  rxg_strobe_t strobe,
  input  logic [7:0]  inData,
  input  logic        inBcast,
  input  logic        inMcast,
  output logic        spaceFresh,
  output logic        spaceCur,
  output logic        qFull,
  output logic        qEmpty,
  output logic        headLast,
  output logic        headBcast,
  output logic        headMcast,
  output logic [7:0]  rdData
);
  localparam int AW = $clog2(DATA_DEPTH);
  localparam int QW = $clog2(STAT_DEPTH);
  localparam int LW = AW + 1;
  localparam logic [AW:0] DFULL = (AW+1)'(DATA_DEPTH);
  localparam logic [QW:0] QFULL = (QW+1)'(STAT_DEPTH);

  logic [7:0]    mem [DATA_DEPTH];
  logic [AW:0]   wrPtr, comPtr, rdPtr;
  logic [AW:0]   wrBase, wrNext;
  logic [LW-1:0] lenCnt, lenBase, lenNext, rdCnt;

  logic [LW-1:0] qLen [STAT_DEPTH];
  logic          qBc  [STAT_DEPTH];
  logic          qMc  [STAT_DEPTH];
  logic [QW:0]   qWr, qRd, qCount;

  // write side: speculative pointer with frame-start base
  always_comb begin
    wrBase  = strobe.restart ? comPtr : wrPtr;
    lenBase = strobe.restart ? '0 : lenCnt;
    wrNext  = wrBase + (AW+1)'(strobe.wrEn);
    lenNext = lenBase + LW'(strobe.wrEn);
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrBase[AW-1:0]] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      comPtr <= '0;
      lenCnt <= '0;
    end else begin
      if (strobe.rollback) begin
        wrPtr  <= comPtr;
        lenCnt <= '0;
      end else if (strobe.commit) begin
        wrPtr  <= wrNext;
        comPtr <= wrNext;
        lenCnt <= '0;
      end else begin
        wrPtr  <= wrNext;
        lenCnt <= lenNext;
      end
    end
  end

  // status side queue
  always_ff @(posedge clk) begin
    if (strobe.commit) begin
      qLen[qWr[QW-1:0]] <= lenNext;
      qBc[qWr[QW-1:0]]  <= inBcast;
      qMc[qWr[QW-1:0]]  <= inMcast;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qWr   <= '0;
      qRd   <= '0;
      rdPtr <= '0;
      rdCnt <= '0;
    end else begin
      if (strobe.commit) qWr <= qWr + 1'b1;
      if (strobe.pop)    qRd <= qRd + 1'b1;
      if (strobe.rdEn)   rdPtr <= rdPtr + 1'b1;
      if (strobe.pop)       rdCnt <= '0;
      else if (strobe.rdEn) rdCnt <= rdCnt + 1'b1;
    end
  end

  always_comb begin
    qCount     = qWr - qRd;
    qFull      = (qCount == QFULL);
    qEmpty     = (qCount == '0);
    spaceFresh = ((comPtr - rdPtr) != DFULL);
    spaceCur   = ((wrPtr - rdPtr) != DFULL);
    headLast   = (rdCnt == qLen[qRd[QW-1:0]] - LW'(1));
    headBcast  = qBc[qRd[QW-1:0]];
    headMcast  = qMc[qRd[QW-1:0]];
    rdData     = mem[rdPtr[AW-1:0]];
  end
endmodule

// File: rtl/rxg_control.sv
module rxg_control
  import rxg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSof,
  input  logic        inEof,
  input  logic        inCrcErr,
  input  logic        inDribble,
  input  logic        outReady,
  input  logic        spaceFresh,
  input  logic        spaceCur,
  input  logic        qFull,
  input  logic        qEmpty,
  input  logic        headLast,
  output rxg_strobe_t strobe,
  output logic        outValid,
  output logic        statCrcErr,
  output logic        statDribble,
  output logic        statOverflow
);
  logic inFrame;
  logic accept, space, clean, ovfEvent, endEvent;

  always_comb begin
    strobe   = '0;
    accept   = inValid && (inSof || inFrame);
    space    = inSof ? spaceFresh : spaceCur;
    clean    = !inCrcErr && !inDribble;
    outValid = !qEmpty;
    if (accept) begin
      strobe.restart = inSof;
      if (!space) begin
        strobe.rollback = 1'b1;
      end else begin
        strobe.wrEn = 1'b1;
        if (inEof) begin
          if (clean && !qFull) strobe.commit   = 1'b1;
          else                 strobe.rollback = 1'b1;
        end
      end
    end
    strobe.rdEn = outValid && outReady;
    strobe.pop  = strobe.rdEn && headLast;
    ovfEvent    = accept && (!space || (inEof && clean && qFull));
    endEvent    = accept && space && inEof;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame      <= 1'b0;
      statCrcErr   <= 1'b0;
      statDribble  <= 1'b0;
      statOverflow <= 1'b0;
    end else begin
      if (accept) inFrame <= space && !inEof;
      if (endEvent) begin
        statCrcErr  <= inCrcErr;
        statDribble <= inDribble;
      end
      if (ovfEvent) statOverflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_frame_gate.sv
module rx_frame_gate
  import rxg_pkg::*;
#(
  parameter int DATA_DEPTH = 64,
  parameter int STAT_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       inSof,
  input  logic       inEof,
  input  logic       inBcast,
  input  logic       inMcast,
  input  logic       inCrcErr,
  input  logic       inDribble,
  input  logic       outReady,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outLast,
  output logic       statBcast,
  output logic       statMcast,
  output logic       statCrcErr,
  output logic       statDribble,
  output logic       statOverflow,
  output logic       rdyReg,
  output logic       rdyFifo
);
  rxg_strobe_t strobe;
  logic spaceFresh, spaceCur, qFull, qEmpty, headLast, headBcast, headMcast;

  rxg_control u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inCrcErr(inCrcErr), .inDribble(inDribble), .outReady(outReady),
    .spaceFresh(spaceFresh), .spaceCur(spaceCur), .qFull(qFull), .qEmpty(qEmpty),
    .headLast(headLast), .strobe(strobe), .outValid(outValid),
    .statCrcErr(statCrcErr), .statDribble(statDribble), .statOverflow(statOverflow)
  );

  rxg_datapath #(.DATA_DEPTH(DATA_DEPTH), .STAT_DEPTH(STAT_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .inBcast(inBcast), .inMcast(inMcast), .spaceFresh(spaceFresh),
    .spaceCur(spaceCur), .qFull(qFull), .qEmpty(qEmpty), .headLast(headLast),
    .headBcast(headBcast), .headMcast(headMcast), .rdData(outData)
  );

  assign outLast   = outValid && headLast;
  assign statBcast = outValid && headBcast;
  assign statMcast = outValid && headMcast;
  assign rdyReg    = !qEmpty;
  assign rdyFifo   = !qEmpty;
endmodule

// File: rtl/rxg_checker.sv
module rxg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inEof,
  input logic       inCrcErr,
  input logic       inDribble,
  input logic       outReady,
  input logic       outValid,
  input logic [7:0] outData,
  input logic       outLast,
  input logic       statBcast,
  input logic       statMcast,
  input logic       statCrcErr,
  input logic       statDribble,
  input logic       statOverflow,
  input logic       rdyReg,
  input logic       rdyFifo
);
  AST_FLAGS_WITH_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rdyReg |-> (rdyFifo && outValid)); // R2
  AST_IDLE_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!statBcast && !statMcast)); // R3
  AST_CRC_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statCrcErr) |-> $past(inValid && inEof && inCrcErr)); // R4
  AST_DRIBBLE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statDribble) |-> $past(inValid && inEof && inDribble)); // R5
  AST_ERR_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (!rdyReg && inValid && inEof && (inCrcErr || inDribble)) |=> !rdyReg); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    statOverflow |=> statOverflow); // R7
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast))); // R8
endmodule

bind rx_frame_gate rxg_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inEof(inEof), .inCrcErr(inCrcErr),
  .inDribble(inDribble), .outReady(outReady), .outValid(outValid), .outData(outData),
  .outLast(outLast), .statBcast(statBcast), .statMcast(statMcast),
  .statCrcErr(statCrcErr), .statDribble(statDribble), .statOverflow(statOverflow),
  .rdyReg(rdyReg), .rdyFifo(rdyFifo)
);

// File: tb/rx_frame_gate_tb.sv
module rx_frame_gate_tb;
  localparam int DD = 32;
  localparam int QD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic inBcast = 1'b0, inMcast = 1'b0, inCrcErr = 1'b0, inDribble = 1'b0;
  logic [7:0] inData = '0;
  logic outReady = 1'b0;
  logic outValid, outLast, statBcast, statMcast, statCrcErr, statDribble, statOverflow;
  logic rdyReg, rdyFifo;
  logic [7:0] outData;

  always #2 clk = ~clk;

  rx_frame_gate #(.DATA_DEPTH(DD), .STAT_DEPTH(QD)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inSof(inSof),
    .inEof(inEof), .inBcast(inBcast), .inMcast(inMcast), .inCrcErr(inCrcErr),
    .inDribble(inDribble), .outReady(outReady), .outValid(outValid),
    .outData(outData), .outLast(outLast), .statBcast(statBcast),
    .statMcast(statMcast), .statCrcErr(statCrcErr), .statDribble(statDribble),
    .statOverflow(statOverflow), .rdyReg(rdyReg), .rdyFifo(rdyFifo)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model
  logic [7:0] modData[$];
  int  modLen[$];
  bit  modBc[$];
  bit  modMc[$];
  int  stored = 0;
  bit  expCrc = 0, expDrb = 0, expOvf = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit predictOvf(int len);
    return (stored + len) > DD;
  endfunction

  task automatic checkStatus(string tag);
    chk(statCrcErr == expCrc, tag, "statCrcErr", statCrcErr, expCrc);
    chk(statDribble == expDrb, tag, "statDribble", statDribble, expDrb);
    chk(statOverflow == expOvf, tag, "statOverflow", statOverflow, expOvf);
    chk(rdyReg == (modLen.size() > 0), tag, "rdyReg", rdyReg, modLen.size() > 0);
    chk(rdyFifo == (modLen.size() > 0), tag, "rdyFifo", rdyFifo, modLen.size() > 0);
  endtask

  task automatic sendFrame(int len, bit bc, bit mc, bit crc, bit drb, bit noEof, string tag);
    logic [7:0] tmp[$];
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      inValid = 1'b1; inSof = (k == 0); inEof = (k == len - 1) && !noEof;
      inData = 8'($urandom); inBcast = bc; inMcast = mc;
      inCrcErr = crc; inDribble = drb;
      tmp.push_back(inData);
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    inCrcErr = 1'b0; inDribble = 1'b0; inBcast = 1'b0; inMcast = 1'b0;
    if (!noEof) begin
      if (predictOvf(len)) begin
        expOvf = 1;
      end else begin
        expCrc = crc; expDrb = drb;
        if (!crc && !drb) begin
          if (modLen.size() == QD) expOvf = 1;
          else begin
            foreach (tmp[i]) modData.push_back(tmp[i]);
            modLen.push_back(len); modBc.push_back(bc); modMc.push_back(mc);
            stored += len;
          end
        end
      end
      checkStatus(tag);
    end
  endtask

  task automatic drain(bit allowStall);
    int idx = 0;
    while (modLen.size() > 0) begin
      bit r;
      @(negedge clk);
      chk(outValid == 1'b1, "R2", "outValid", outValid, 1);
      chk(outData == modData[0], "R2/R8", "outData", outData, modData[0]);
      chk(outLast == (idx == modLen[0] - 1), "R2", "outLast", outLast, idx == modLen[0] - 1);
      chk(statBcast == modBc[0], "R3", "statBcast", statBcast, modBc[0]);
      chk(statMcast == modMc[0], "R3", "statMcast", statMcast, modMc[0]);
      chk(rdyReg && rdyFifo, "R6", "flags", rdyReg, 1);
      r = allowStall ? (($urandom % 4) != 0) : 1'b1;
      outReady = r;
      if (r) begin
        void'(modData.pop_front());
        stored--;
        idx++;
        if (idx == modLen[0]) begin
          void'(modLen.pop_front()); void'(modBc.pop_front()); void'(modMc.pop_front());
          idx = 0;
        end
      end
    end
    @(negedge clk);
    outReady = 1'b0;
    chk(!outValid, "R6", "outValid after drain", outValid, 0);
    chk(!rdyReg && !rdyFifo, "R6", "flags after drain", rdyReg, 0);
    chk(!statBcast && !statMcast, "R3", "idle class bits", statBcast, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!outValid && !rdyReg && !rdyFifo, "R1", "flags in reset", outValid, 0);
    chk(!statBcast && !statMcast && !statCrcErr && !statDribble && !statOverflow,
        "R1", "status in reset", statCrcErr, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid && !rdyReg && !statOverflow, "R1", "after release", outValid, 0);

    // R2 R3 good frames
    sendFrame(5, 1, 0, 0, 0, 0, "R2");
    drain(0);
    sendFrame(3, 0, 1, 0, 0, 0, "R3");
    sendFrame(2, 1, 0, 0, 0, 0, "R6");
    sendFrame(1, 0, 0, 0, 0, 0, "R6");
    drain(1);

    // R4 CRC error, R5 dribble, R10 cleared by clean end
    sendFrame(4, 1, 0, 1, 0, 0, "R4");
    chk(!outValid, "R4", "crc frame hidden", outValid, 0);
    sendFrame(3, 0, 1, 0, 1, 0, "R5");
    chk(!outValid, "R5", "dribble frame hidden", outValid, 0);
    sendFrame(2, 0, 0, 0, 0, 0, "R10");
    sendFrame(2, 0, 0, 1, 1, 0, "R4");
    drain(1);

    // R9 stray beat and restart
    @(negedge clk);
    inValid = 1'b1; inData = 8'hA5; inEof = 1'b1;
    @(negedge clk);
    inValid = 1'b0; inEof = 1'b0;
    @(negedge clk);
    chk(!outValid && !rdyReg, "R9", "stray beat ignored", outValid, 0);
    sendFrame(3, 1, 1, 0, 0, 1, "R9");
    sendFrame(4, 0, 1, 0, 0, 0, "R9");
    drain(1);

    // R11 exact fit
    sendFrame(DD, 0, 0, 0, 0, 0, "R11");
    drain(0);

    // R7 status queue full
    for (int f = 0; f < QD + 1; f++) sendFrame(2, f[0], 0, 0, 0, 0, "R7");
    drain(1);
    // R7 byte store overflow
    sendFrame(DD + 1, 1, 0, 0, 0, 0, "R7");
    chk(!outValid, "R7", "overflowed frame hidden", outValid, 0);
    sendFrame(3, 0, 0, 0, 0, 0, "R7");
    drain(1);
    chk(statOverflow, "R7", "overflow sticky", statOverflow, 1);

    // random rounds
    for (int it = 0; it < 40; it++) begin
      int n;
      n = 1 + int'($urandom % 3);
      for (int f = 0; f < n; f++) begin
        int len;
        bit crc, drb;
        len = 1 + int'($urandom % 8);
        crc = ($urandom % 5) == 0;
        drb = ($urandom % 5) == 0;
        sendFrame(len, 1'($urandom), 1'($urandom), crc, drb, 0, "R2");
      end
      drain(1);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule